// File: doc/BRIEF.md
# Line Service Flag Scanner

The block holds one service flag for each serial receiver (character assembled) and one for each serial transmitter (ready for another character). It walks all of these flags in one fixed circular order and shows a sequencing controller one pending request at a time.

A request is shown as a valid line number and a direction. The block keeps that request on its outputs until the controller steps it. When stepped, the block sends a one-cycle clear pulse to the serviced flag and resumes the walk at the next position. If the flag at the current position is not set, the walk moves on by one position every clock.

The line count is set by two parameters: the number of groups and the number of lines per group. The default is four groups of four lines.

Top module: `svc_flag_scanner`

## Requirements
- R1: While reset is active, valid_o is low and both clear vectors are zero. After reset is released, the walk starts at position 0 (receive line 0).
- R2: A one-cycle pulse on rx_set_i[n] or tx_set_i[n] sets that line's flag. The flag stays set until it is serviced.
- R3: The walk order is receive lines 0 to NUM_LINES-1, then transmit lines 0 to NUM_LINES-1, then back to receive line 0.
- R4: When the flag at the current position is clear, the position advances by exactly one every clock.
- R5: When the flag at the current position is set, the outputs present it. valid_o is high, line_o holds the line number, and dir_o is 0 for receive or 1 for transmit. Valid, line and direction hold unchanged until step_i arrives.
- R6: In a cycle where step_i and valid_o are both high, the clear vector for the shown direction (clr_rx_o or clr_tx_o) has bit line_o set in that same cycle. The flag is then clear, and the position advances by one.
- R7: step_i while valid_o is low has no effect. No clear pulse is produced and no flag is removed.
- R8: A set pulse in the same cycle as the clear of that flag wins. The flag stays set and is shown again on the next pass.
- R9: Across clr_rx_o and clr_tx_o at most one bit is high, and only in a cycle with valid_o and step_i both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_set_i | input | NUM_LINES | Receiver character-ready pulses, one per line |
| tx_set_i | input | NUM_LINES | Transmitter ready-for-data pulses, one per line |
| step_i | input | 1 | Controller has handled the shown request |
| valid_o | output | 1 | A request is shown |
| line_o | output | LW | Line number of the shown request |
| dir_o | output | 1 | 0 receive, 1 transmit |
| clr_rx_o | output | NUM_LINES | One-cycle clear pulse to a receiver flag |
| clr_tx_o | output | NUM_LINES | One-cycle clear pulse to a transmitter flag |

## Verification
The hold and advance properties only restrict step_i in relation to valid_o. They allow a step in any cycle, and a stray step is expected to be harmless. The clear properties assume that set pulses may arrive at any time, including on the flag being cleared. The stimulus changes inputs only on the falling clock edge. It uses stray steps, pulses that collide with a clear, and several flags set at once, so that every one of these allowed cases is reached.

// File: rtl/svc_scan_pkg.sv
`timescale 1ns/1ps
package svc_scan_pkg;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;
endpackage

// File: rtl/svc_flag_bank.sv
`timescale 1ns/1ps
module svc_flag_bank #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[g] <= 1'b0;
      else if (set_i[g]) flag_q[g] <= 1'b1;  // set beats clear
      else if (clr_i[g]) flag_q[g] <= 1'b0;
    end

    // R8
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_o[g]);
    // R6
    clr_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/svc_scan_pos.sv
`timescale 1ns/1ps
module svc_scan_pos #(
  parameter  int NPOS = 32,
  localparam int PW   = $clog2(NPOS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          step_i,
  output logic [PW-1:0] pos_o
);
  localparam logic [PW-1:0] LAST = PW'(NPOS - 1);

  logic [PW-1:0] pos_q, pos_nxt;
  logic          hold;

  assign hold    = valid_i && !step_i;
  assign pos_nxt = (pos_q == LAST) ? '0 : pos_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= '0;
    else if (!hold) pos_q <= pos_nxt;
  end

  assign pos_o = pos_q;

  // R5
  pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !step_i) |=> (pos_o == $past(pos_o)));
  // R4
  pos_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && !step_i) |=>
      (pos_o == (($past(pos_o) == LAST) ? '0 : $past(pos_o) + PW'(1))));
endmodule

// File: rtl/svc_flag_scanner.sv
`timescale 1ns/1ps
module svc_flag_scanner #(
  parameter  int NUM_GROUPS  = 4,
  parameter  int GROUP_LINES = 4,
  localparam int NUM_LINES   = NUM_GROUPS * GROUP_LINES,
  localparam int LW          = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] rx_set_i,
  input  logic [NUM_LINES-1:0] tx_set_i,
  input  logic                 step_i,
  output logic                 valid_o,
  output logic [LW-1:0]        line_o,
  output logic                 dir_o,
  output logic [NUM_LINES-1:0] clr_rx_o,
  output logic [NUM_LINES-1:0] clr_tx_o
);
  import svc_scan_pkg::*;

  localparam int NPOS = 2 * NUM_LINES;
  localparam int PW   = $clog2(NPOS);

  logic [NUM_LINES-1:0] rx_flag, tx_flag, clr_rx, clr_tx;
  logic [NPOS-1:0]      all_flag;
  logic [PW-1:0]        pos;
  logic [LW-1:0]        line;
  dir_e                 dir;
  logic                 valid, take;

  svc_flag_bank #(.N(NUM_LINES)) u_rx_bank (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (rx_set_i), .clr_i (clr_rx), .flag_o (rx_flag)
  );

  svc_flag_bank #(.N(NUM_LINES)) u_tx_bank (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (tx_set_i), .clr_i (clr_tx), .flag_o (tx_flag)
  );

  // receive positions first, transmit positions after
  assign all_flag = {tx_flag, rx_flag};

  always_comb begin
    valid = all_flag[pos];
    if (pos >= PW'(NUM_LINES)) begin
      dir  = DIR_TX;
      line = LW'(pos - PW'(NUM_LINES));
    end else begin
      dir  = DIR_RX;
      line = LW'(pos);
    end
    take   = valid && step_i;
    clr_rx = '0;
    clr_tx = '0;
    if (take) begin
      if (dir == DIR_RX) clr_rx[line] = 1'b1;
      else               clr_tx[line] = 1'b1;
    end
  end

  svc_scan_pos #(.NPOS(NPOS)) u_pos (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .valid_i (valid), .step_i (step_i), .pos_o (pos)
  );

  assign valid_o  = valid;
  assign line_o   = line;
  assign dir_o    = dir;
  assign clr_rx_o = clr_rx;
  assign clr_tx_o = clr_tx;

  // R9
  clr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clr_tx_o, clr_rx_o}));
  // R9
  clr_needs_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{clr_tx_o, clr_rx_o}) |-> (valid_o && step_i));
  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !step_i) |=> (valid_o && $stable(line_o) && $stable(dir_o)));
  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && clr_rx_o == '0 && clr_tx_o == '0));
endmodule

// File: tb/svc_flag_scanner_bench.sv
`timescale 1ns/1ps
module svc_flag_scanner_bench;
  localparam int NL = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NL-1:0] rx_set = '0, tx_set = '0;
  logic          step = 1'b0;
  logic          valid_o, dir_o;
  logic [3:0]    line_o;
  logic [NL-1:0] clr_rx_o, clr_tx_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  svc_flag_scanner u_svc_flag_scanner (
    .clk_i (clk), .rst_ni (rst_ni),
    .rx_set_i (rx_set), .tx_set_i (tx_set), .step_i (step),
    .valid_o (valid_o), .line_o (line_o), .dir_o (dir_o),
    .clr_rx_o (clr_rx_o), .clr_tx_o (clr_tx_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!valid_o && n < 80) begin
      tick();
      n++;
    end
  endtask

  // steps the shown request; returns position and clear bits seen
  task automatic service(output int p, output int clr_bits, output int clr_cnt);
    p = int'(dir_o) * NL + int'(line_o);
    step = 1'b1;
    #1;
    clr_bits = dir_o ? int'(clr_tx_o) : int'(clr_rx_o);
    clr_cnt  = $countones({clr_tx_o, clr_rx_o});
    tick();
    step = 1'b0;
  endtask

  task automatic t_reset_start();
    int n, p, cb, cc;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", int'(valid_o), 0);
    chk("R1", "clears in reset", int'({clr_tx_o, clr_rx_o} != '0), 0);
    rst_ni = 1'b1;
    rx_set[10] = 1'b1;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    rx_set = '0;
    while (!valid_o && n < 80) begin
      tick();
      n++;
    end
    chk("R1", "edges from release to rx10", n, 10);  // also R4
    chk("R4", "line found", int'(line_o), 10);
    chk("R5", "dir rx", int'(dir_o), 0);
    service(p, cb, cc);
    chk("R6", "clr_rx pulse", cb, 1 << 10);
    chk("R6", "flag gone", int'(valid_o), 0);
  endtask

  task automatic t_hold_tx();
    int n, p, cb, cc, seen;
    tx_set[6] = 1'b1;
    tick();
    tx_set = '0;
    wait_valid(n);
    chk("R2", "tx6 found", int'(valid_o), 1);
    chk("R5", "dir tx", int'(dir_o), 1);
    chk("R5", "line 6", int'(line_o), 6);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R5", "held valid", int'(valid_o), 1);
      chk("R5", "held line", int'(line_o), 6);
      chk("R9", "no clear without step", int'({clr_tx_o, clr_rx_o} != '0), 0);
    end
    service(p, cb, cc);
    chk("R6", "clr_tx pulse", cb, 1 << 6);
    chk("R9", "one clear bit", cc, 1);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (valid_o) seen = 1;
      tick();
    end
    chk("R6", "tx6 cleared", seen, 0);
  endtask

  task automatic t_order();
    int exp_pos[4] = '{0, 9, 18, 31};
    int n, p, cb, cc, idx, seen;
    rx_set[0] = 1'b1; rx_set[9] = 1'b1;
    tx_set[2] = 1'b1; tx_set[15] = 1'b1;
    tick();
    rx_set = '0; tx_set = '0;
    idx = -1;
    for (int k = 0; k < 4; k++) begin
      wait_valid(n);
      chk("R2", "pending found", int'(valid_o), 1);
      service(p, cb, cc);
      chk("R9", "one clear bit", cc, 1);
      if (k == 0) begin
        for (int j = 0; j < 4; j++) if (exp_pos[j] == p) idx = j;
        chk("R3", "first is pending", int'(idx >= 0), 1);
      end else begin
        chk("R3", "scan order", p, exp_pos[(idx + k) % 4]);
      end
    end
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      if (valid_o) seen = 1;
      tick();
    end
    chk("R3", "all serviced once", seen, 0);
  endtask

  task automatic t_collision();
    int n;
    rx_set[7] = 1'b1;
    tick();
    rx_set = '0;
    wait_valid(n);
    chk("R8", "rx7 shown", int'(line_o), 7);
    step = 1'b1;
    rx_set[7] = 1'b1;
    #1;
    chk("R8", "clear still pulses", int'(clr_rx_o), 1 << 7);
    tick();
    step = 1'b0;
    rx_set = '0;
    wait_valid(n);
    chk("R8", "re-shown after full pass", n, 31);
    chk("R8", "line kept", int'(line_o), 7);
    chk("R8", "dir kept", int'(dir_o), 0);
    step = 1'b1;
    tick();
    step = 1'b0;
  endtask

  task automatic t_stray_step();
    int n, bad;
    bad = 0;
    step = 1'b1;
    for (int i = 0; i < 10; i++) begin
      #1;
      if ({clr_tx_o, clr_rx_o} != '0 || valid_o) bad++;
      tick();
    end
    step = 1'b0;
    chk("R7", "stray step clears", bad, 0);
    rx_set[3] = 1'b1;
    tick();
    rx_set = '0;
    step = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    step = 1'b0;
    wait_valid(n);
    chk("R7", "flag kept", int'(valid_o), 1);
    chk("R7", "line 3", int'(line_o), 3);
    step = 1'b1;
    tick();
    step = 1'b0;
  endtask

  initial begin
    t_reset_start();
    t_hold_tx();
    t_order();
    t_collision();
    t_stray_step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule